// File: doc/BRIEF.md
# Directory Coherence Cache-Node Controller

This block is the coherence controller on the cache side of one node in a distributed-memory machine where a home directory keeps track of every cached block. It holds a small direct-mapped cache. Each line stores one data word, an address tag and a coherence state: invalid, shared (read-only) or exclusive (read/write, memory stale). Processor loads and stores that cannot be served locally become point-to-point request messages to the home directory. The processor is held in a stall until the directory's data reply arrives.

The same block takes requests that the directory sends to it: drop a copy, return an owned copy and keep it read-only, or return an owned copy and drop it. When the line is owned it answers with a data write-back message. When a miss would evict an owned line, the dirty word is written back before the miss request is sent. One outgoing message register with a valid/ready handshake carries all traffic to the network. Incoming messages are taken one per cycle, in the order they arrive.

Top module: `cohm_node_ctrl`

## Requirements
- R1: After a synchronous active-high reset every line is invalid, no outgoing message is valid, `cpu_done` and `cpu_stall` are low and `in_ready` is high.
- R2: A processor read whose line holds a matching tag in the shared or exclusive state completes with `cpu_done` high for one cycle, the stored word on `cpu_rdata`, and no outgoing message.
- R3: A processor read that misses sends a read-miss message (kind 0) carrying the node number, the full address and a zero data field. When a data reply (kind 5) is accepted, the line becomes shared with the reply word and the read completes returning that word.
- R4: A processor write to a line that is invalid, holds another tag or is shared sends a write-miss message (kind 1). After the data reply the line is exclusive and holds the written word. A write to a matching exclusive line updates the word with no message.
- R5: An invalidate message (kind 2) whose address matches a present line makes that line invalid, so the next processor access to it misses. No message is sent in reply.
- R6: A fetch message (kind 3) that matches an exclusive line sends a data write-back (kind 6) with that address and the stored word, and leaves the line shared.
- R7: A fetch-and-invalidate message (kind 4) that matches an exclusive line sends a data write-back (kind 6) with the address and word, and leaves the line invalid.
- R8: A processor miss whose line is exclusive under another tag first sends a data write-back of the evicted address and word, and only then sends the miss request.
- R9: While `out_valid` is high and `out_ready` is low, the outgoing message stays valid and all its fields hold steady.
- R10: An invalidate, fetch or fetch-and-invalidate whose address has no matching line, and a fetch of either kind to a line that is only shared, changes nothing and produces no message.
- R11: `cpu_stall` is high while a processor request waits. `in_ready` is low whenever an outgoing message is pending, so incoming messages are taken one at a time and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Processor word address |
| cpu_wdata | input | 16 | Processor write word |
| cpu_stall | output | 1 | Processor must wait |
| cpu_done | output | 1 | Access finishes this cycle |
| cpu_rdata | output | 16 | Read result, valid with `cpu_done` |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network accepts the outgoing message |
| out_kind | output | 3 | Outgoing message kind |
| out_node | output | 4 | Number of this node |
| out_addr | output | 10 | Outgoing message address |
| out_data | output | 16 | Outgoing message data word |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Incoming message accepted this cycle |
| in_kind | input | 3 | Incoming message kind |
| in_addr | input | 10 | Incoming message address |
| in_data | input | 16 | Incoming reply data |

## Verification
The state machine is driven with read and write sequences against lines in each of the three states. Repeated hits are separated from upgrades, and upgrades from conflict misses on one index, which tells a silent completion apart from a miss with or without a write-back in front of it. Directory requests are sent to owned, shared and absent lines, so a write-back answer can be told from a silent state change or from no effect at all. Random back-pressure on the outgoing port shows whether messages stay steady and whether incoming traffic waits its turn.

// File: rtl/cohm_pkg.sv
package cohm_pkg;

    localparam int CW_ADDR = 10;
    localparam int CW_DATA = 16;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        M_RDMISS   = 3'd0,
        M_WRMISS   = 3'd1,
        M_INVAL    = 3'd2,
        M_FETCH    = 3'd3,
        M_FETCHINV = 3'd4,
        M_REPLY    = 3'd5,
        M_WBACK    = 3'd6
    } msg_e;

    typedef struct packed {
        msg_e                kind;
        logic [CW_ADDR-1:0]  addr;
        logic [CW_DATA-1:0]  data;
    } msg_t;

    function automatic msg_t mk_msg(msg_e k, logic [CW_ADDR-1:0] a, logic [CW_DATA-1:0] d);
        msg_t m;
        m.kind = k;
        m.addr = a;
        m.data = d;
        return m;
    endfunction

endpackage

// File: rtl/cohm_line_store.sv
module cohm_line_store
    import cohm_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int TAG_W   = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_st,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_st,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    line_st_e          st_all  [N_LINES];
    logic [TAG_W-1:0]  tag_all [N_LINES];
    logic [DATA_W-1:0] dat_all [N_LINES];

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        line_st_e          st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] dat_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r  <= LN_INV;
                tag_r <= '0;
                dat_r <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                st_r  <= wr_st;
                tag_r <= wr_tag;
                dat_r <= wr_data;
            end
        end

        assign st_all[i]  = st_r;
        assign tag_all[i] = tag_r;
        assign dat_all[i] = dat_r;
    end

    assign ra_st   = st_all[ra_idx];
    assign ra_tag  = tag_all[ra_idx];
    assign ra_data = dat_all[ra_idx];
    assign rb_st   = st_all[rb_idx];
    assign rb_tag  = tag_all[rb_idx];
    assign rb_data = dat_all[rb_idx];

endmodule

// File: rtl/cohm_msg_out.sv
module cohm_msg_out
    import cohm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  msg_t load_msg,
    output logic out_valid,
    input  logic out_ready,
    output msg_t out_msg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_msg   <= mk_msg(M_RDMISS, '0, '0);
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (load) begin
                out_valid <= 1'b1;
                out_msg   <= load_msg;
            end
        end
    end

    // R9: a waiting message is neither dropped nor altered
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_msg)));

    // R9: the register is only loaded when it is empty
    always_ff @(posedge clk) begin
        if (!rst) p_load_free_r9: assert (!(load && out_valid));
    end

endmodule

// File: rtl/cohm_node_ctrl.sv
module cohm_node_ctrl
    import cohm_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int NODE_W  = 4,
    parameter int NODE_ID = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [CW_ADDR-1:0] cpu_addr,
    input  logic [CW_DATA-1:0] cpu_wdata,
    output logic               cpu_stall,
    output logic               cpu_done,
    output logic [CW_DATA-1:0] cpu_rdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [2:0]         out_kind,
    output logic [NODE_W-1:0]  out_node,
    output logic [CW_ADDR-1:0] out_addr,
    output logic [CW_DATA-1:0] out_data,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [2:0]         in_kind,
    input  logic [CW_ADDR-1:0] in_addr,
    input  logic [CW_DATA-1:0] in_data
);

    localparam int IDX_W = $clog2(N_LINES);
    localparam int TAG_W = CW_ADDR - IDX_W;

    typedef enum logic [1:0] {F_IDLE, F_SEND, F_WAIT, F_DONE} fsm_e;

    fsm_e               fsm_q, fsm_n;
    logic [CW_ADDR-1:0] r_addr;
    logic               r_we;
    logic [CW_DATA-1:0] r_wdata;
    logic [CW_DATA-1:0] rdata_q, rdata_n;
    logic               rdata_ld, start;

    logic [IDX_W-1:0]   ra_idx, rb_idx, wr_idx;
    line_st_e           ra_st, rb_st, wr_st;
    logic [TAG_W-1:0]   ra_tag, rb_tag, wr_tag;
    logic [CW_DATA-1:0] ra_data, rb_data, wr_data;
    logic               wr_en;

    logic               ld;
    msg_t               ld_msg, om;

    logic [CW_ADDR-1:0] cur_addr;
    logic [TAG_W-1:0]   ctag, itag;
    logic               c_hit, i_hit, in_fire;
    msg_e               ikind;

    // directory-request reaction
    logic               dir_wr_en, dir_ld;
    line_st_e           dir_wr_st;
    msg_t               dir_msg;

    assign ikind    = msg_e'(in_kind);
    assign cur_addr = (fsm_q == F_IDLE) ? cpu_addr : r_addr;
    assign ra_idx   = cur_addr[IDX_W-1:0];
    assign ctag     = cur_addr[CW_ADDR-1:IDX_W];
    assign c_hit    = (ra_st != LN_INV) && (ra_tag == ctag);
    assign rb_idx   = in_addr[IDX_W-1:0];
    assign itag     = in_addr[CW_ADDR-1:IDX_W];
    assign i_hit    = (rb_st != LN_INV) && (rb_tag == itag);
    assign in_ready = !out_valid && (fsm_q == F_IDLE || fsm_q == F_WAIT);
    assign in_fire  = in_valid && in_ready;

    cohm_line_store #(
        .N_LINES (N_LINES),
        .TAG_W   (TAG_W),
        .DATA_W  (CW_DATA)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (ra_idx),
        .ra_st   (ra_st),
        .ra_tag  (ra_tag),
        .ra_data (ra_data),
        .rb_idx  (rb_idx),
        .rb_st   (rb_st),
        .rb_tag  (rb_tag),
        .rb_data (rb_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_st   (wr_st),
        .wr_tag  (wr_tag),
        .wr_data (wr_data)
    );

    cohm_msg_out u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (ld),
        .load_msg  (ld_msg),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_msg   (om)
    );

    always_comb begin
        dir_wr_en = 1'b0;
        dir_wr_st = rb_st;
        dir_ld    = 1'b0;
        dir_msg   = mk_msg(M_WBACK, in_addr, rb_data);
        if (i_hit) begin
            unique case (ikind)
                M_INVAL: begin
                    dir_wr_en = 1'b1;
                    dir_wr_st = LN_INV;
                end
                M_FETCH: if (rb_st == LN_EXC) begin
                    dir_wr_en = 1'b1;
                    dir_wr_st = LN_SHR;
                    dir_ld    = 1'b1;
                end
                M_FETCHINV: if (rb_st == LN_EXC) begin
                    dir_wr_en = 1'b1;
                    dir_wr_st = LN_INV;
                    dir_ld    = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        fsm_n    = fsm_q;
        wr_en    = 1'b0;
        wr_idx   = rb_idx;
        wr_st    = rb_st;
        wr_tag   = rb_tag;
        wr_data  = rb_data;
        ld       = 1'b0;
        ld_msg   = dir_msg;
        rdata_ld = 1'b0;
        rdata_n  = ra_data;
        start    = 1'b0;
        unique case (fsm_q)
            F_IDLE: begin
                if (in_fire) begin
                    wr_en = dir_wr_en;
                    wr_st = dir_wr_st;
                    ld    = dir_ld;
                end else if (cpu_req && !out_valid) begin
                    start = 1'b1;
                    if (!cpu_we && c_hit) begin
                        rdata_ld = 1'b1;
                        fsm_n    = F_DONE;
                    end else if (cpu_we && c_hit && ra_st == LN_EXC) begin
                        wr_en   = 1'b1;
                        wr_idx  = ra_idx;
                        wr_st   = LN_EXC;
                        wr_tag  = ctag;
                        wr_data = cpu_wdata;
                        fsm_n   = F_DONE;
                    end else if (ra_st == LN_EXC && ra_tag != ctag) begin
                        ld      = 1'b1;
                        ld_msg  = mk_msg(M_WBACK, {ra_tag, ra_idx}, ra_data);
                        wr_en   = 1'b1;
                        wr_idx  = ra_idx;
                        wr_st   = LN_INV;
                        wr_tag  = ra_tag;
                        wr_data = ra_data;
                        fsm_n   = F_SEND;
                    end else begin
                        ld     = 1'b1;
                        ld_msg = mk_msg(cpu_we ? M_WRMISS : M_RDMISS, cpu_addr, '0);
                        fsm_n  = F_WAIT;
                    end
                end
            end
            F_SEND: begin
                if (!out_valid) begin
                    ld     = 1'b1;
                    ld_msg = mk_msg(r_we ? M_WRMISS : M_RDMISS, r_addr, '0);
                    fsm_n  = F_WAIT;
                end
            end
            F_WAIT: begin
                if (in_fire) begin
                    if (ikind == M_REPLY) begin
                        wr_en    = 1'b1;
                        wr_idx   = ra_idx;
                        wr_st    = r_we ? LN_EXC : LN_SHR;
                        wr_tag   = ctag;
                        wr_data  = r_we ? r_wdata : in_data;
                        rdata_ld = 1'b1;
                        rdata_n  = in_data;
                        fsm_n    = F_DONE;
                    end else begin
                        wr_en = dir_wr_en;
                        wr_st = dir_wr_st;
                        ld    = dir_ld;
                    end
                end
            end
            F_DONE: fsm_n = F_IDLE;
            default: fsm_n = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q   <= F_IDLE;
            r_addr  <= '0;
            r_we    <= 1'b0;
            r_wdata <= '0;
            rdata_q <= '0;
        end else begin
            fsm_q <= fsm_n;
            if (start) begin
                r_addr  <= cpu_addr;
                r_we    <= cpu_we;
                r_wdata <= cpu_wdata;
            end
            if (rdata_ld) rdata_q <= rdata_n;
        end
    end

    assign cpu_done  = (fsm_q == F_DONE);
    assign cpu_stall = cpu_req && !cpu_done;
    assign cpu_rdata = rdata_q;
    assign out_kind  = om.kind;
    assign out_addr  = om.addr;
    assign out_data  = om.data;
    assign out_node  = NODE_W'(NODE_ID);

    // R6: an owned line hit by a fetch answers with a write-back of that address
    p_fetch_wb_r6: assert property (@(posedge clk) disable iff (rst)
        (in_fire && ikind == M_FETCH && i_hit && rb_st == LN_EXC)
        |=> (out_valid && out_kind == 3'd6 && out_addr == $past(in_addr)));

    // R7: same for fetch-and-invalidate
    p_fetchinv_wb_r7: assert property (@(posedge clk) disable iff (rst)
        (in_fire && ikind == M_FETCHINV && i_hit && rb_st == LN_EXC)
        |=> (out_valid && out_kind == 3'd6 && out_addr == $past(in_addr)));

    // R10: a request for an absent line produces nothing
    p_absent_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (in_fire && !i_hit && (ikind == M_INVAL || ikind == M_FETCH || ikind == M_FETCHINV))
        |=> !out_valid);

    // R8: while the miss waits behind an eviction only the write-back is on the port
    p_wb_first_r8: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == F_SEND && out_valid) |-> (out_kind == 3'd6));

    // R11: an access never completes with a message still pending
    p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !out_valid);

endmodule

// File: tb/sim_cohm_node_ctrl.sv
module sim_cohm_node_ctrl;

    localparam int NODE = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we;
    logic [9:0]  cpu_addr;
    logic [15:0] cpu_wdata;
    logic        cpu_stall, cpu_done;
    logic [15:0] cpu_rdata;
    logic        out_valid, out_ready;
    logic [2:0]  out_kind;
    logic [3:0]  out_node;
    logic [9:0]  out_addr;
    logic [15:0] out_data;
    logic        in_valid, in_ready;
    logic [2:0]  in_kind;
    logic [9:0]  in_addr;
    logic [15:0] in_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model: 0 invalid, 1 shared, 2 exclusive
    int m_st [4];
    int m_tag [4];
    int m_data [4];

    always #2 clk = ~clk;

    cohm_node_ctrl #(.N_LINES(4), .NODE_W(4), .NODE_ID(NODE)) u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_node(out_node), .out_addr(out_addr), .out_data(out_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_addr(in_addr), .in_data(in_data)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_msg(int kind, logic [9:0] addr, logic [15:0] data, string req);
        bit got = 0;
        for (int c = 0; c < 40 && !got; c++) begin
            @(negedge clk);
            out_ready = ($urandom % 3) != 0;
            if (out_valid) begin
                chk(out_kind == 3'(kind), req, "msg kind", int'(out_kind), kind);
                chk(out_addr == addr, req, "msg addr", int'(out_addr), int'(addr));
                chk(out_data == data, req, "msg data", int'(out_data), int'(data));
                chk(out_node == 4'(NODE), req, "msg node", int'(out_node), NODE);
                chk(in_ready == 1'b0, "R11", "in_ready while msg pending", int'(in_ready), 0);
                if (out_ready) got = 1;
            end
        end
        if (!got) chk(1'b0, req, "message missing", 0, kind);
    endtask

    task automatic wait_done(string req, bit is_rd, logic [15:0] exp_rd);
        int c = 0;
        while (!cpu_done && c < 40) begin
            @(negedge clk);
            c++;
        end
        chk(cpu_done == 1'b1, req, "cpu_done", int'(cpu_done), 1);
        chk(out_valid == 1'b0, req, "no message at completion", int'(out_valid), 0);
        if (is_rd) chk(cpu_rdata == exp_rd, req, "read data", int'(cpu_rdata), int'(exp_rd));
        cpu_req = 1'b0;
    endtask

    task automatic do_cpu(bit we, logic [9:0] addr, logic [15:0] wd);
        int idx = int'(addr[1:0]);
        int tg  = int'(addr[9:2]);
        bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
        logic [15:0] rd;
        @(negedge clk);
        out_ready = 1'b0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        #1;
        chk(cpu_stall == 1'b1, "R11", "stall while pending", int'(cpu_stall), 1);
        if (!we && hit) begin
            wait_done("R2", 1'b1, 16'(m_data[idx]));
        end else if (we && hit && m_st[idx] == 2) begin
            wait_done("R4", 1'b0, 16'h0);
            m_data[idx] = int'(wd);
        end else begin
            if (m_st[idx] == 2 && m_tag[idx] != tg) begin
                expect_msg(6, {8'(m_tag[idx]), 2'(idx)}, 16'(m_data[idx]), "R8");
                m_st[idx] = 0;
            end
            expect_msg(we ? 1 : 0, addr, 16'h0, we ? "R4" : "R3");
            rd = 16'($urandom);
            @(negedge clk);
            out_ready = 1'b0;
            chk(in_ready == 1'b1, "R11", "ready for reply", int'(in_ready), 1);
            in_valid = 1'b1; in_kind = 3'd5; in_addr = addr; in_data = rd;
            @(negedge clk);
            in_valid = 1'b0;
            wait_done(we ? "R4" : "R3", !we, rd);
            m_st[idx]   = we ? 2 : 1;
            m_tag[idx]  = tg;
            m_data[idx] = we ? int'(wd) : int'(rd);
        end
    endtask

    task automatic dir_msg(int kind, logic [9:0] addr);
        int idx = int'(addr[1:0]);
        int tg  = int'(addr[9:2]);
        bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready == 1'b1, "R11", "in_ready idle", int'(in_ready), 1);
        in_valid = 1'b1; in_kind = 3'(kind); in_addr = addr; in_data = 16'($urandom);
        @(negedge clk);
        in_valid = 1'b0;
        if ((kind == 3 || kind == 4) && hit && m_st[idx] == 2) begin
            expect_msg(6, addr, 16'(m_data[idx]), kind == 3 ? "R6" : "R7");
            m_st[idx] = (kind == 3) ? 1 : 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                chk(out_valid == 1'b0, (kind == 2 && hit) ? "R5" : "R10",
                    "no reply message", int'(out_valid), 0);
                @(negedge clk);
            end
            if (kind == 2 && hit) m_st[idx] = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_data[i] = 0; end
        rst = 1'b1; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        out_ready = 0; in_valid = 0; in_kind = 0; in_addr = 0; in_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(cpu_done == 1'b0, "R1", "cpu_done after reset", int'(cpu_done), 0);
        chk(cpu_stall == 1'b0, "R1", "cpu_stall after reset", int'(cpu_stall), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // directed: R3 miss, R2 hit, R4 upgrade and exclusive hit
        do_cpu(1'b0, 10'h005, 16'h0);
        do_cpu(1'b0, 10'h005, 16'h0);
        do_cpu(1'b1, 10'h005, 16'hA1B2);
        do_cpu(1'b1, 10'h005, 16'hC3D4);
        do_cpu(1'b0, 10'h005, 16'h0);
        // R6 fetch then read hit, then write needs upgrade
        dir_msg(3, 10'h005);
        do_cpu(1'b0, 10'h005, 16'h0);
        do_cpu(1'b1, 10'h005, 16'h5555);
        // R7 fetch-and-invalidate, next read misses
        dir_msg(4, 10'h005);
        do_cpu(1'b0, 10'h005, 16'h0);
        // R5 invalidate of a shared line, then miss again
        dir_msg(2, 10'h005);
        do_cpu(1'b0, 10'h005, 16'h0);
        // R10 fetch to shared line, absent address, tag mismatch
        dir_msg(3, 10'h005);
        dir_msg(4, 10'h3F5);
        dir_msg(2, 10'h012);
        // R8 eviction of an owned line
        do_cpu(1'b1, 10'h001, 16'hBEEF);
        do_cpu(1'b0, 10'h011, 16'h0);
        do_cpu(1'b1, 10'h021, 16'h1234);
        do_cpu(1'b1, 10'h031, 16'h4321);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom % 10);
            logic [9:0] a = 10'((($urandom % 6) << 2) | ($urandom % 4));
            if (r >= 7 && ($urandom % 2) == 1 && m_st[a[1:0]] != 0)
                a = {8'(m_tag[a[1:0]]), a[1:0]};
            if (r < 4)       do_cpu(1'b0, a, 16'h0);
            else if (r < 7)  do_cpu(1'b1, a, 16'($urandom));
            else if (r == 7) dir_msg(2, a);
            else if (r == 8) dir_msg(3, a);
            else             dir_msg(4, a);
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule